// File: doc/BRIEF.md
# Breaker Failure Timing Logic

This block decides that a circuit breaker has not cleared a fault after a trip was sent to it, and escalates. A trip initiation can come in several forms: a single-phase initiation for each phase, a three-phase initiation from line protection, a three-phase initiation from generator or transformer protection, and a three-phase initiation for faults that draw little current. Each form is qualified against current magnitudes computed upstream. The phase current is always used. The zero-sequence and negative-sequence currents are used where enabled. For the low-current initiation, a breaker auxiliary contact that reports the breaker as still closed can also qualify.

A qualified initiation runs four outputs. Per-phase and three-phase re-trip commands repeat the trip to the same breaker. A stage-1 three-phase trip goes to the local breaker. A stage-2 trip goes to all adjacent breakers. Each output has its own delay, counted in 1 ms ticks from a strobe input. A timer starts again from zero whenever its condition drops. The block input and the enable inputs silence every output at once.

Top module: `bkr_fail_timing`

## Requirements
- R1: `func_on` is high exactly when `en_in` and `en_set` are both high. While `func_on` is low, every trip and re-trip output is low.
- R2: With `en_retrip` high, `retrip_ph[k]` (bit 0 = A, bit 1 = B, bit 2 = C) goes high `d_retrip` ticks after `init_ph[k]` and that phase's current both qualify. Another phase's current never qualifies it, and with `en_retrip` low it stays low.
- R3: With `en_retrip` high, `retrip_3p` follows a line or generator/transformer three-phase initiation that comes with any phase current above setting.
- R4: `trip_stage1` goes high after `d_stage1` ticks and `trip_stage2` after `d_stage2` ticks when the failure condition holds. The failure condition is met by a single-phase initiation with its own phase current above setting, or by a line three-phase initiation with any phase current above setting.
- R5: A generator/transformer initiation also qualifies the failure condition through the zero-sequence current when `en_zs_3p` is high, and through the negative-sequence current when `en_ns_3p` is high. A line initiation never uses the sequence currents.
- R6: A single-phase initiation also qualifies the failure condition through the zero-sequence current when `en_zs_1p` is high. This path does not drive the per-phase re-trip.
- R7: The low-current initiation qualifies the failure condition through any phase current, or through `cb_aux_closed` when `en_aux_chk` is high.
- R8: A current qualifies only when it is strictly greater than its setting. A current equal to its setting does not qualify.
- R9: A delay of 0 operates in the same cycle as the condition. A delay of N operates after the Nth `tick_ms` pulse seen while the condition holds.
- R10: When a condition drops, its output falls at once and its timer restarts from zero.
- R11: While `block_in` is high, all trip outputs are low and all timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| en_in | input | 1 | Enable from binary input |
| en_set | input | 1 | Enable setting |
| block_in | input | 1 | Function block |
| init_ph | input | 3 | Single-phase initiations, bit 0 = A |
| init_line3p | input | 1 | Three-phase initiation from line protection |
| init_gt3p | input | 1 | Three-phase initiation from generator/transformer protection |
| init_nocur | input | 1 | Three-phase low-current initiation |
| cb_aux_closed | input | 1 | Auxiliary contact reports breaker still closed |
| i_ph_a | input | CUR_W | Phase A current magnitude |
| i_ph_b | input | CUR_W | Phase B current magnitude |
| i_ph_c | input | CUR_W | Phase C current magnitude |
| i_zs | input | CUR_W | Zero-sequence current magnitude |
| i_ns | input | CUR_W | Negative-sequence current magnitude |
| set_i_ph | input | CUR_W | Phase current setting |
| set_i_zs | input | CUR_W | Zero-sequence current setting |
| set_i_ns | input | CUR_W | Negative-sequence current setting |
| en_retrip | input | 1 | Re-trip enable |
| en_zs_1p | input | 1 | Zero-sequence criterion for single-phase initiation |
| en_zs_3p | input | 1 | Zero-sequence criterion for generator/transformer initiation |
| en_ns_3p | input | 1 | Negative-sequence criterion for generator/transformer initiation |
| en_aux_chk | input | 1 | Auxiliary-contact criterion for low-current initiation |
| d_retrip | input | DLY_W | Re-trip delay in ms |
| d_stage1 | input | DLY_W | Stage-1 delay in ms |
| d_stage2 | input | DLY_W | Stage-2 delay in ms |
| func_on | output | 1 | Function enabled |
| retrip_ph | output | 3 | Per-phase re-trip, bit 0 = A |
| retrip_3p | output | 1 | Three-phase re-trip |
| trip_stage1 | output | 1 | Stage-1 local three-phase trip |
| trip_stage2 | output | 1 | Stage-2 adjacent-breaker trip |

## Verification
A wrong qualification term shows up at once: with all delays at zero, the matching output is wrong in the same cycle as the input pattern. A timer that is not cleared, or that counts wrong, shows at the port on the tick where the output should or should not rise. After a condition drops or the block input pulses, the stale count shows as an early trip within fewer ticks than the delay setting. The bench therefore drives ticks one at a time and checks the outputs after every tick.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int unsigned PH_N     = 3;
  localparam int unsigned CUR_W_D  = 16;
  localparam int unsigned DLY_W_D  = 14;
  localparam int unsigned CMP_N    = PH_N + 2;
  localparam int unsigned IDX_ZS   = PH_N;
  localparam int unsigned IDX_NS   = PH_N + 1;
  localparam int unsigned RT_N     = PH_N + 1;

  function automatic logic exceeds(input logic [31:0] mag, input logic [31:0] thr);
    return mag > thr;
  endfunction
endpackage

// File: rtl/bf_cmp.sv
module bf_cmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] mag,
  input  logic [W-1:0] thr,
  output logic         over
);
  assign over = bfp_pkg::exceeds(32'(mag), 32'(thr));
endmodule

// File: rtl/bf_qualify.sv
module bf_qualify
  import bfp_pkg::*;
(
  input  logic [PH_N-1:0] init_ph,
  input  logic            init_line3p,
  input  logic            init_gt3p,
  input  logic            init_nocur,
  input  logic            cb_aux_closed,
  input  logic [PH_N-1:0] ph_over,
  input  logic            zs_over,
  input  logic            ns_over,
  input  logic            en_zs_1p,
  input  logic            en_zs_3p,
  input  logic            en_ns_3p,
  input  logic            en_aux_chk,
  output logic [PH_N-1:0] rt_ph_req,
  output logic            rt_3p_req,
  output logic            bf_req
);
  logic            any_ph;
  logic [PH_N-1:0] single_q;
  logic            line_q, gt_q, nocur_q;

  assign any_ph    = |ph_over;
  assign rt_ph_req = init_ph & ph_over;
  assign rt_3p_req = (init_line3p | init_gt3p) & any_ph;

  // single-phase path: own phase current, optionally zero-sequence
  assign single_q = init_ph & (ph_over | {PH_N{en_zs_1p & zs_over}});
  assign line_q   = init_line3p & any_ph;
  assign gt_q     = init_gt3p & (any_ph | (en_zs_3p & zs_over) | (en_ns_3p & ns_over));
  assign nocur_q  = init_nocur & (any_ph | (en_aux_chk & cb_aux_closed));

  assign bf_req = (|single_q) | line_q | gt_q | nocur_q;
endmodule

// File: rtl/bf_delay.sv
module bf_delay #(
  parameter int unsigned DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cond,
  input  logic [DW-1:0] limit,
  output logic          fire
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!cond)                cnt <= '0;
    else if (tick && cnt < limit)  cnt <= cnt + 1'b1;
  end

  assign fire = cond && (cnt >= limit);
endmodule

// File: rtl/bkr_fail_timing.sv
module bkr_fail_timing
  import bfp_pkg::*;
#(
  parameter int unsigned CUR_W = CUR_W_D,
  parameter int unsigned DLY_W = DLY_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             en_in,
  input  logic             en_set,
  input  logic             block_in,
  input  logic [2:0]       init_ph,
  input  logic             init_line3p,
  input  logic             init_gt3p,
  input  logic             init_nocur,
  input  logic             cb_aux_closed,
  input  logic [CUR_W-1:0] i_ph_a,
  input  logic [CUR_W-1:0] i_ph_b,
  input  logic [CUR_W-1:0] i_ph_c,
  input  logic [CUR_W-1:0] i_zs,
  input  logic [CUR_W-1:0] i_ns,
  input  logic [CUR_W-1:0] set_i_ph,
  input  logic [CUR_W-1:0] set_i_zs,
  input  logic [CUR_W-1:0] set_i_ns,
  input  logic             en_retrip,
  input  logic             en_zs_1p,
  input  logic             en_zs_3p,
  input  logic             en_ns_3p,
  input  logic             en_aux_chk,
  input  logic [DLY_W-1:0] d_retrip,
  input  logic [DLY_W-1:0] d_stage1,
  input  logic [DLY_W-1:0] d_stage2,
  output logic             func_on,
  output logic [2:0]       retrip_ph,
  output logic             retrip_3p,
  output logic             trip_stage1,
  output logic             trip_stage2
);
  logic [CUR_W-1:0] mag [CMP_N];
  logic [CUR_W-1:0] thr [CMP_N];
  logic [CMP_N-1:0] over;

  assign mag[0] = i_ph_a;  assign thr[0] = set_i_ph;
  assign mag[1] = i_ph_b;  assign thr[1] = set_i_ph;
  assign mag[2] = i_ph_c;  assign thr[2] = set_i_ph;
  assign mag[IDX_ZS] = i_zs;  assign thr[IDX_ZS] = set_i_zs;
  assign mag[IDX_NS] = i_ns;  assign thr[IDX_NS] = set_i_ns;

  for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
    bf_cmp #(.W(CUR_W)) u_cmp (.mag(mag[g]), .thr(thr[g]), .over(over[g]));
  end

  logic [PH_N-1:0] rt_ph_req;
  logic            rt_3p_req, bf_req;

  bf_qualify u_qual (
    .init_ph(init_ph), .init_line3p(init_line3p), .init_gt3p(init_gt3p),
    .init_nocur(init_nocur), .cb_aux_closed(cb_aux_closed),
    .ph_over(over[PH_N-1:0]), .zs_over(over[IDX_ZS]), .ns_over(over[IDX_NS]),
    .en_zs_1p(en_zs_1p), .en_zs_3p(en_zs_3p), .en_ns_3p(en_ns_3p),
    .en_aux_chk(en_aux_chk),
    .rt_ph_req(rt_ph_req), .rt_3p_req(rt_3p_req), .bf_req(bf_req)
  );

  // named internal events, observed by the checker
  logic            active;
  logic [RT_N-1:0] rt_arm;
  logic            bf_arm;
  logic [RT_N-1:0] rt_fire;

  assign func_on = en_in & en_set;
  assign active  = func_on & ~block_in;
  assign rt_arm  = {rt_3p_req, rt_ph_req} & {RT_N{active & en_retrip}};
  assign bf_arm  = bf_req & active;

  for (genvar r = 0; r < RT_N; r++) begin : g_rt
    bf_delay #(.DW(DLY_W)) u_rt (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms), .cond(rt_arm[r]),
      .limit(d_retrip), .fire(rt_fire[r])
    );
  end

  bf_delay #(.DW(DLY_W)) u_st1 (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .cond(bf_arm),
    .limit(d_stage1), .fire(trip_stage1)
  );
  bf_delay #(.DW(DLY_W)) u_st2 (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .cond(bf_arm),
    .limit(d_stage2), .fire(trip_stage2)
  );

  assign retrip_ph = rt_fire[PH_N-1:0];
  assign retrip_3p = rt_fire[PH_N];
endmodule

// File: rtl/bf_timing_chk.sv
module bf_timing_chk #(
  parameter int unsigned DLY_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_ms,
  input logic             func_on,
  input logic             block_in,
  input logic             en_retrip,
  input logic [2:0]       init_ph,
  input logic             bf_arm,
  input logic [DLY_W-1:0] d_stage1,
  input logic [DLY_W-1:0] d_stage2,
  input logic [2:0]       retrip_ph,
  input logic             retrip_3p,
  input logic             trip_stage1,
  input logic             trip_stage2
);
  logic any_out;
  assign any_out = trip_stage1 | trip_stage2 | retrip_3p | (|retrip_ph);

  // R11
  block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_in |-> !any_out);

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !func_on |-> !any_out);

  // R2
  retrip_own_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|retrip_ph) |-> (((retrip_ph & ~init_ph) == 3'b000) && en_retrip));

  // R4
  stage_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_stage1 | trip_stage2) |-> bf_arm);

  // R9
  stage2_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trip_stage2) && d_stage2 != '0 && $stable(d_stage2)) |-> $past(tick_ms));

  // R10
  stage1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bf_arm) && bf_arm && d_stage1 != '0) |-> !trip_stage1);
endmodule

bind bkr_fail_timing bf_timing_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .func_on(func_on),
  .block_in(block_in), .en_retrip(en_retrip), .init_ph(init_ph),
  .bf_arm(bf_arm), .d_stage1(d_stage1), .d_stage2(d_stage2),
  .retrip_ph(retrip_ph), .retrip_3p(retrip_3p),
  .trip_stage1(trip_stage1), .trip_stage2(trip_stage2)
);

// File: tb/bkr_fail_timing_tb.sv
module bkr_fail_timing_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CUR_W = 16;
  localparam int DLY_W = 14;
  localparam logic [CUR_W-1:0] HI = 16'd200, LO = 16'd50, SET = 16'd100;

  logic clk = 0, rst_n = 0, tick_ms = 0;
  logic en_in = 1, en_set = 1, block_in = 0;
  logic [2:0] init_ph = 0;
  logic init_line3p = 0, init_gt3p = 0, init_nocur = 0, cb_aux_closed = 0;
  logic [CUR_W-1:0] i_ph_a = LO, i_ph_b = LO, i_ph_c = LO, i_zs = LO, i_ns = LO;
  logic en_retrip = 1, en_zs_1p = 0, en_zs_3p = 0, en_ns_3p = 0, en_aux_chk = 0;
  logic [DLY_W-1:0] d_retrip = 0, d_stage1 = 0, d_stage2 = 0;
  logic func_on, retrip_3p, trip_stage1, trip_stage2;
  logic [2:0] retrip_ph;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkr_fail_timing #(.CUR_W(CUR_W), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .en_in(en_in), .en_set(en_set),
    .block_in(block_in), .init_ph(init_ph), .init_line3p(init_line3p),
    .init_gt3p(init_gt3p), .init_nocur(init_nocur), .cb_aux_closed(cb_aux_closed),
    .i_ph_a(i_ph_a), .i_ph_b(i_ph_b), .i_ph_c(i_ph_c), .i_zs(i_zs), .i_ns(i_ns),
    .set_i_ph(SET), .set_i_zs(SET), .set_i_ns(SET), .en_retrip(en_retrip),
    .en_zs_1p(en_zs_1p), .en_zs_3p(en_zs_3p), .en_ns_3p(en_ns_3p),
    .en_aux_chk(en_aux_chk), .d_retrip(d_retrip), .d_stage1(d_stage1),
    .d_stage2(d_stage2), .func_on(func_on), .retrip_ph(retrip_ph),
    .retrip_3p(retrip_3p), .trip_stage1(trip_stage1), .trip_stage2(trip_stage2)
  );

  // outputs packed as {retrip_ph, retrip_3p, stage1, stage2}
  function automatic logic [5:0] outs();
    return {retrip_ph, retrip_3p, trip_stage1, trip_stage2};
  endfunction

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic one_tick();
    @(negedge clk); tick_ms = 1;
    @(negedge clk); tick_ms = 0; #1;
  endtask

  task automatic clear_inputs();
    init_ph = 0; init_line3p = 0; init_gt3p = 0; init_nocur = 0; cb_aux_closed = 0;
    i_ph_a = LO; i_ph_b = LO; i_ph_c = LO; i_zs = LO; i_ns = LO;
    en_zs_1p = 0; en_zs_3p = 0; en_ns_3p = 0; en_aux_chk = 0;
  endtask

  // fields: iph[21:19] line[18] gt[17] nocur[16] aux[15] phhi[14:12] zshi[11] nshi[10]
  //         ezs1[9] ezs3[8] ens3[7] eaux[6] | expected rph[5:3] r3p[2] st1[1] st2[0]
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {3'b001,4'b0000,3'b001,2'b00,4'b0000, 3'b001,1'b0,2'b11}, // R2 R4 phase A
    {3'b010,4'b0000,3'b001,2'b00,4'b0000, 3'b000,1'b0,2'b00}, // R2 wrong phase current
    {3'b100,4'b0000,3'b100,2'b00,4'b0000, 3'b100,1'b0,2'b11}, // R2 phase C
    {3'b001,4'b0000,3'b000,2'b10,4'b0000, 3'b000,1'b0,2'b00}, // R6 zs disabled
    {3'b001,4'b0000,3'b000,2'b10,4'b1000, 3'b000,1'b0,2'b11}, // R6 zs enabled
    {3'b000,4'b1000,3'b010,2'b00,4'b0000, 3'b000,1'b1,2'b11}, // R3 R4 line
    {3'b000,4'b1000,3'b000,2'b10,4'b0100, 3'b000,1'b0,2'b00}, // R5 line ignores zs
    {3'b000,4'b0100,3'b000,2'b10,4'b0100, 3'b000,1'b0,2'b11}, // R5 gen zs
    {3'b000,4'b0100,3'b000,2'b01,4'b0000, 3'b000,1'b0,2'b00}, // R5 ns disabled
    {3'b000,4'b0100,3'b000,2'b01,4'b0010, 3'b000,1'b0,2'b11}, // R5 ns enabled
    {3'b000,4'b0011,3'b000,2'b00,4'b0000, 3'b000,1'b0,2'b00}, // R7 aux disabled
    {3'b000,4'b0011,3'b000,2'b00,4'b0001, 3'b000,1'b0,2'b11}, // R7 aux enabled
    {3'b000,4'b0010,3'b100,2'b00,4'b0000, 3'b000,1'b0,2'b11}  // R7 phase current
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 reset idle", outs(), 6'b0);
    chk("R1 func_on both enables", {5'b0, func_on}, 6'd1);

    // table walk, all delays zero (R9 immediate)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      init_ph = VEC[v][21:19]; init_line3p = VEC[v][18]; init_gt3p = VEC[v][17];
      init_nocur = VEC[v][16]; cb_aux_closed = VEC[v][15];
      i_ph_a = VEC[v][12] ? HI : LO; i_ph_b = VEC[v][13] ? HI : LO;
      i_ph_c = VEC[v][14] ? HI : LO; i_zs = VEC[v][11] ? HI : LO; i_ns = VEC[v][10] ? HI : LO;
      en_zs_1p = VEC[v][9]; en_zs_3p = VEC[v][8]; en_ns_3p = VEC[v][7]; en_aux_chk = VEC[v][6];
      #1;
      chk($sformatf("R9 table vector %0d", v), outs(), VEC[v][5:0]);
    end

    // R8 equality does not qualify
    @(negedge clk); clear_inputs(); init_ph = 3'b001; i_ph_a = SET; #1;
    chk("R8 equal current", outs(), 6'b0);
    @(negedge clk); i_ph_a = SET + 1'b1; #1;
    chk("R8 one above", outs(), 6'b001011);

    // R2 re-trip disabled, stage paths unaffected
    @(negedge clk); en_retrip = 0; #1;
    chk("R2 retrip disabled", outs(), 6'b000011);
    @(negedge clk); en_retrip = 1;

    // R1 enable off
    @(negedge clk); en_in = 0; #1;
    chk("R1 en_in low", {func_on, outs()[4:0]}, 6'b0);
    @(negedge clk); en_in = 1; en_set = 0; #1;
    chk("R1 en_set low", {func_on, outs()[4:0]}, 6'b0);
    @(negedge clk); en_set = 1; clear_inputs(); #1;

    // R9 timing with delays 2/3/5
    @(negedge clk); d_retrip = 2; d_stage1 = 3; d_stage2 = 5;
    init_ph = 3'b001; i_ph_a = HI; #1;
    chk("R9 start", outs(), 6'b0);
    one_tick(); chk("R9 tick1", outs(), 6'b000000);
    one_tick(); chk("R9 tick2 retrip", outs(), 6'b001000);
    one_tick(); chk("R9 tick3 stage1", outs(), 6'b001010);
    one_tick(); chk("R9 tick4", outs(), 6'b001010);
    one_tick(); chk("R9 tick5 stage2", outs(), 6'b001011);

    // R10 drop and restart
    @(negedge clk); init_ph = 0; #1;
    chk("R10 drop", outs(), 6'b0);
    @(negedge clk); init_ph = 3'b001; #1;
    chk("R10 restart", outs(), 6'b0);
    one_tick(); one_tick();
    chk("R10 two ticks after restart", outs(), 6'b001000);

    // R11 block clears
    @(negedge clk); block_in = 1; #1;
    chk("R11 block", outs(), 6'b0);
    @(negedge clk); block_in = 0; #1;
    chk("R11 after release", outs(), 6'b0);
    one_tick(); one_tick();
    chk("R11 cleared count", outs(), 6'b001000);
    one_tick();
    chk("R11 recount stage1", outs(), 6'b001010);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule